// File: doc/BRIEF.md
# Boost Conduction-Boundary Gate Sequencer

This block drives the gate-enable of a boost power-factor stage that must stay in discontinuous or critical conduction. A period begins on a cycle-start event, which comes either from an internal tick counter or from the falling edge of an external sync line. Each start is held in a pending latch. The switch turns on only when the synchronized zero-current flag shows that the inductor has run dry. If current is still flowing when a new period begins, the turn-on waits, and the stage slides into critical conduction. It never runs in continuous conduction.

Once the gate is on, a ramp counter measures the on-time against the requested value. The request is clamped to a parameter maximum. An overcurrent flag ends the pulse early and drops any pending start. A fault-disable input clears all sequencing state. A status bit reports whether the most recent turn-on was delayed waiting for zero current (critical) or was immediate (discontinuous).

Top module: `pfc_gate_seq`

## Requirements
- R1: While rst_n is low, gate_on and crm_active are 0.
- R2: In sync mode (mode_sync = 1), a sync_in low pulse of at least SYNC_MIN cycles makes gate_on rise on the (SYNC_MIN+3)rd rising clock edge after sync_in falls, provided zc_in has been high and oc_in low.
- R3: A sync_in low pulse shorter than SYNC_MIN clock cycles starts no period. A pulse of exactly SYNC_MIN cycles starts one.
- R4: gate_on never rises unless the synchronized zero-current flag was high in the preceding cycle. A pending start waits for zc_in, and gate_on rises on the third rising edge after zc_in goes high.
- R5: Each pulse lasts exactly min(ton_req, TON_MAX) clock cycles. A request of 0 produces no pulse and consumes the pending start.
- R6: crm_active becomes 1 at a turn-on that waited at least one cycle for zero current, and 0 at an immediate turn-on. It holds that value until the next turn-on.
- R7: When oc_in rises, gate_on is low by the third rising edge. A pending start is discarded, and no pulse follows until a cycle start that occurs while the overcurrent flag is clear.
- R8: fault_dis high forces gate_on low at the next edge, clears the pending start and holds the on-time counter at zero. Once fault_dis is released, nothing switches until a new cycle start.
- R9: In tick mode (mode_sync = 0), a cycle start occurs exactly once every OSC_PERIOD clock cycles, and sync_in is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sync | input | 1 | 1: external sync starts periods; 0: internal tick |
| sync_in | input | 1 | External sync line, asynchronous, idle high |
| zc_in | input | 1 | Zero inductor current flag, asynchronous |
| oc_in | input | 1 | Overcurrent flag, asynchronous |
| fault_dis | input | 1 | Synchronous global disable |
| ton_req | input | TON_W | Requested on-time in clock cycles |
| gate_on | output | 1 | Registered gate enable |
| crm_active | output | 1 | 1: last turn-on was critical-mode; 0: discontinuous |

## Verification
The properties assume that fault_dis is already synchronous to clk. They also assume that the flags reach the sequencer only through the two-flop synchronizers, so every relation is stated against the synchronized flags and the registered gate. The stimulus changes every asynchronous input on the falling clock edge and holds each level for at least several cycles, so each synchronizer output settles with a fixed two-edge latency. The bench counts expected edges from that latency, and every pulse-width window is long enough to contain a whole pulse.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;

   typedef enum logic {
      SRC_TICK = 1'b0,
      SRC_SYNC = 1'b1
   } src_sel_e;

   localparam int unsigned LANE_SYNC = 0;
   localparam int unsigned LANE_ZC   = 1;
   localparam int unsigned LANE_OC   = 2;
   localparam int unsigned LANES     = 3;

endpackage

// File: rtl/pfc_sync_chain.sv
module pfc_sync_chain #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pfc_sync_chain: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pfc_cycle_src.sv
module pfc_cycle_src
   import pfc_gate_pkg::*;
#(
   parameter int unsigned OSC_PERIOD = 500,
   parameter int unsigned SYNC_MIN   = 25
) (
   input  logic     clk,
   input  logic     rst_n,
   input  src_sel_e src_sel,
   input  logic     sync_s,
   output logic     cyc_start
);

   localparam int unsigned OSC_W = $clog2(OSC_PERIOD);
   localparam logic [OSC_W-1:0] OSC_LAST = OSC_W'(OSC_PERIOD - 1);

   logic [OSC_W-1:0] tick_cnt;
   logic             tick_evt;
   logic             sync_evt;

   assign tick_evt = (tick_cnt == OSC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tick_cnt <= '0;
      else if (tick_evt) tick_cnt <= '0;
      else               tick_cnt <= tick_cnt + 1'b1;
   end

   if (SYNC_MIN <= 1) begin : g_edge_only
      logic sync_prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_prev <= 1'b1;
         else        sync_prev <= sync_s;
      end
      assign sync_evt = sync_prev & ~sync_s;
   end else begin : g_width_filter
      localparam int unsigned LOW_W = $clog2(SYNC_MIN + 1);
      localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(SYNC_MIN);
      localparam logic [LOW_W-1:0] LOW_HIT  = LOW_W'(SYNC_MIN - 1);
      logic [LOW_W-1:0] low_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 low_cnt <= '0;
         else if (sync_s)            low_cnt <= '0;
         else if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
      end
      assign sync_evt = ~sync_s & (low_cnt == LOW_HIT);
   end

   assign cyc_start = (src_sel == SRC_SYNC) ? sync_evt : tick_evt;

endmodule

// File: rtl/pfc_gate_core.sv
module pfc_gate_core #(
   parameter int unsigned TON_W   = 10,
   parameter int unsigned TON_MAX = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_start,
   input  logic             zc_s,
   input  logic             oc_s,
   input  logic             fault_dis,
   input  logic [TON_W-1:0] ton_req,
   output logic             gate_q,
   output logic             crm_q
);

   localparam logic [TON_W-1:0] TON_MAX_V = TON_W'(TON_MAX);

   logic [TON_W-1:0] ton_eff;
   logic [TON_W-1:0] ramp_q;
   logic             pend_q;
   logic             waited_q;
   logic             on_done;
   logic             fire;

   assign ton_eff = (ton_req > TON_MAX_V) ? TON_MAX_V : ton_req;
   assign on_done = (({1'b0, ramp_q} + (TON_W+1)'(1)) >= {1'b0, ton_eff});
   assign fire    = pend_q & zc_s & ~gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q   <= 1'b0;
         crm_q    <= 1'b0;
         pend_q   <= 1'b0;
         waited_q <= 1'b0;
         ramp_q   <= '0;
      end else if (fault_dis) begin
         gate_q   <= 1'b0;
         crm_q    <= 1'b0;
         pend_q   <= 1'b0;
         waited_q <= 1'b0;
         ramp_q   <= '0;
      end else if (oc_s) begin
         gate_q   <= 1'b0;
         pend_q   <= 1'b0;
         waited_q <= 1'b0;
         ramp_q   <= '0;
      end else begin
         if (gate_q) begin
            if (on_done) begin
               gate_q <= 1'b0;
               ramp_q <= '0;
            end else begin
               ramp_q <= ramp_q + 1'b1;
            end
         end
         if (cyc_start) begin
            pend_q   <= 1'b1;
            waited_q <= 1'b0;
         end else if (fire) begin
            pend_q   <= 1'b0;
            gate_q   <= (ton_eff != '0);
            ramp_q   <= '0;
            crm_q    <= waited_q;
            waited_q <= 1'b0;
         end else if (pend_q && !zc_s) begin
            waited_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pfc_gate_seq.sv
module pfc_gate_seq
   import pfc_gate_pkg::*;
#(
   parameter int unsigned TON_W      = 10,
   parameter int unsigned TON_MAX    = 1000,
   parameter int unsigned OSC_PERIOD = 500,
   parameter int unsigned SYNC_MIN   = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_sync,
   input  logic             sync_in,
   input  logic             zc_in,
   input  logic             oc_in,
   input  logic             fault_dis,
   input  logic [TON_W-1:0] ton_req,
   output logic             gate_on,
   output logic             crm_active
);

   if (TON_MAX < 1 || TON_MAX >= (1 << TON_W)) begin : g_bad_ton
      $error("pfc_gate_seq: TON_MAX must be in 1 .. 2**TON_W-1");
   end
   if (OSC_PERIOD < 2) begin : g_bad_osc
      $error("pfc_gate_seq: OSC_PERIOD must be at least 2");
   end
   if (SYNC_MIN < 1) begin : g_bad_sync
      $error("pfc_gate_seq: SYNC_MIN must be at least 1");
   end

   localparam logic [LANES-1:0] LANE_RST = LANES'(1) << LANE_SYNC;

   logic [LANES-1:0] raw_in;
   logic [LANES-1:0] syn_q;
   logic             cyc_start;
   src_sel_e         src_sel;

   assign raw_in[LANE_SYNC] = sync_in;
   assign raw_in[LANE_ZC]   = zc_in;
   assign raw_in[LANE_OC]   = oc_in;
   assign src_sel = mode_sync ? SRC_SYNC : SRC_TICK;

   pfc_sync_chain #(
      .WIDTH   (LANES),
      .STAGES  (2),
      .RST_VAL (LANE_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_in),
      .q_sync  (syn_q)
   );

   pfc_cycle_src #(
      .OSC_PERIOD (OSC_PERIOD),
      .SYNC_MIN   (SYNC_MIN)
   ) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_sel   (src_sel),
      .sync_s    (syn_q[LANE_SYNC]),
      .cyc_start (cyc_start)
   );

   pfc_gate_core #(
      .TON_W   (TON_W),
      .TON_MAX (TON_MAX)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (cyc_start),
      .zc_s      (syn_q[LANE_ZC]),
      .oc_s      (syn_q[LANE_OC]),
      .fault_dis (fault_dis),
      .ton_req   (ton_req),
      .gate_q    (gate_on),
      .crm_q     (crm_active)
   );

endmodule

// File: rtl/pfc_gate_core_chk.sv
module pfc_gate_core_chk #(
   parameter int unsigned TON_W   = 10,
   parameter int unsigned TON_MAX = 1000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             zc_s,
   input logic             oc_s,
   input logic             fault_dis,
   input logic             gate_q,
   input logic             pend_q,
   input logic [TON_W-1:0] ramp_q
);

   // R4: a turn-on is always preceded by a zero-current observation
   p_zero_current_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q) |-> $past(zc_s));

   // R2: a turn-on always consumes a pending start
   p_pending_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q) |-> $past(pend_q));

   // R7: overcurrent takes the gate down at the next edge
   p_oc_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      oc_s |=> !gate_q);

   // R8: disable clears gate, pending start and counter
   p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_dis |=> (!gate_q && !pend_q && ramp_q == '0));

   // R5: the on-time counter stays under the clamp while on
   p_ton_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gate_q |-> (ramp_q < TON_W'(TON_MAX)));

endmodule

bind pfc_gate_core pfc_gate_core_chk #(
   .TON_W   (TON_W),
   .TON_MAX (TON_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .zc_s      (zc_s),
   .oc_s      (oc_s),
   .fault_dis (fault_dis),
   .gate_q    (gate_q),
   .pend_q    (pend_q),
   .ramp_q    (ramp_q)
);

// File: tb/tb_pfc_gate_seq.sv
module tb_pfc_gate_seq;

   localparam int unsigned TON_W      = 8;
   localparam int unsigned TON_MAX    = 20;
   localparam int unsigned OSC_PERIOD = 40;
   localparam int unsigned SYNC_MIN   = 4;
   localparam int unsigned NVEC       = 7;

   // each entry: {requested on-time, expected pulse width}
   localparam int VEC [NVEC][2] = '{
      '{5, 5}, '{1, 1}, '{20, 20}, '{21, 20}, '{50, 20}, '{0, 0}, '{13, 13}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             mode_sync;
   logic             sync_in;
   logic             zc_in;
   logic             oc_in;
   logic             fault_dis;
   logic [TON_W-1:0] ton_req;
   logic             gate_on;
   logic             crm_active;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pfc_gate_seq #(
      .TON_W      (TON_W),
      .TON_MAX    (TON_MAX),
      .OSC_PERIOD (OSC_PERIOD),
      .SYNC_MIN   (SYNC_MIN)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_sync  (mode_sync),
      .sync_in    (sync_in),
      .zc_in      (zc_in),
      .oc_in      (oc_in),
      .fault_dis  (fault_dis),
      .ton_req    (ton_req),
      .gate_on    (gate_on),
      .crm_active (crm_active)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic sync_pulse(input int w);
      @(negedge clk);
      sync_in = 1'b0;
      repeat (w) @(negedge clk);
      sync_in = 1'b1;
   endtask

   task automatic watch(input int n, output int hi, output int rises);
      logic prev;
      hi = 0;
      rises = 0;
      prev = gate_on;
      repeat (n) begin
         @(negedge clk);
         if (gate_on) hi++;
         if (gate_on && !prev) rises++;
         prev = gate_on;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int hi;
      int rs;
      rst_n = 1'b0; mode_sync = 1'b1; sync_in = 1'b1; zc_in = 1'b1;
      oc_in = 1'b0; fault_dis = 1'b0; ton_req = 8'd5;
      repeat (4) @(negedge clk);
      chk(gate_on == 1'b0, "R1 gate in reset", int'(gate_on), 0);
      chk(crm_active == 1'b0, "R1 crm in reset", int'(crm_active), 0);
      rst_n = 1'b1;
      watch(10, hi, rs);
      chk(hi == 0, "R1 idle after reset", hi, 0);

      // R2: latency from sync fall to gate rise
      @(negedge clk);
      sync_in = 1'b0;
      for (int k = 1; k <= SYNC_MIN + 3; k++) begin
         @(negedge clk);
         if (k == SYNC_MIN + 2) chk(gate_on == 1'b0, "R2 before rise", int'(gate_on), 0);
         if (k == SYNC_MIN + 3) chk(gate_on == 1'b1, "R2 rise edge", int'(gate_on), 1);
      end
      sync_in = 1'b1;
      watch(30, hi, rs);

      // R5: table of on-time requests
      for (int v = 0; v < NVEC; v++) begin
         ton_req = TON_W'(VEC[v][0]);
         sync_pulse(SYNC_MIN);
         watch(60, hi, rs);
         chk(hi == VEC[v][1], "R5 pulse width", hi, VEC[v][1]);
         chk(rs == (VEC[v][1] != 0 ? 1 : 0), "R5 pulse count", rs, (VEC[v][1] != 0 ? 1 : 0));
      end

      // R3: short sync pulse rejected, minimum width accepted
      ton_req = 8'd5;
      sync_pulse(SYNC_MIN - 1);
      watch(40, hi, rs);
      chk(rs == 0, "R3 short sync ignored", rs, 0);
      sync_pulse(SYNC_MIN);
      watch(40, hi, rs);
      chk(rs == 1, "R3 minimum width accepted", rs, 1);
      chk(crm_active == 1'b0, "R6 immediate turn-on is DCM", int'(crm_active), 0);

      // R4/R6: wait for zero current
      @(negedge clk);
      zc_in = 1'b0;
      repeat (3) @(negedge clk);
      sync_pulse(SYNC_MIN + 2);
      watch(30, hi, rs);
      chk(hi == 0, "R4 no gate while current flows", hi, 0);
      zc_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(gate_on == 1'b0, "R4 before zc seen", int'(gate_on), 0);
      @(negedge clk);
      chk(gate_on == 1'b1, "R4 rise after zc", int'(gate_on), 1);
      chk(crm_active == 1'b1, "R6 delayed turn-on is CRM", int'(crm_active), 1);
      watch(40, hi, rs);
      chk(crm_active == 1'b1, "R6 CRM held", int'(crm_active), 1);
      sync_pulse(SYNC_MIN);
      watch(40, hi, rs);
      chk(crm_active == 1'b0, "R6 back to DCM", int'(crm_active), 0);

      // R7: overcurrent
      ton_req = 8'd20;
      sync_pulse(SYNC_MIN);
      repeat (5) @(negedge clk);
      chk(gate_on == 1'b1, "R7 pulse running", int'(gate_on), 1);
      oc_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(gate_on == 1'b1, "R7 before oc reaches gate", int'(gate_on), 1);
      @(negedge clk);
      chk(gate_on == 1'b0, "R7 gate cut", int'(gate_on), 0);
      repeat (5) @(negedge clk);
      oc_in = 1'b0;
      watch(40, hi, rs);
      chk(hi == 0, "R7 no restart without start", hi, 0);
      oc_in = 1'b1;
      repeat (3) @(negedge clk);
      sync_pulse(SYNC_MIN);
      watch(20, hi, rs);
      oc_in = 1'b0;
      watch(40, hi, rs);
      chk(hi == 0, "R7 start during oc dropped", hi, 0);
      sync_pulse(SYNC_MIN);
      watch(40, hi, rs);
      chk(hi == 20, "R7 resumes at next start", hi, 20);

      // R8: fault disable
      zc_in = 1'b0;
      repeat (3) @(negedge clk);
      sync_pulse(SYNC_MIN);
      repeat (5) @(negedge clk);
      fault_dis = 1'b1;
      @(negedge clk);
      fault_dis = 1'b0;
      zc_in = 1'b1;
      watch(40, hi, rs);
      chk(hi == 0, "R8 pending cleared", hi, 0);
      sync_pulse(SYNC_MIN);
      repeat (6) @(negedge clk);
      chk(gate_on == 1'b1, "R8 pulse running", int'(gate_on), 1);
      fault_dis = 1'b1;
      @(negedge clk);
      chk(gate_on == 1'b0, "R8 gate forced low", int'(gate_on), 0);
      fault_dis = 1'b0;
      watch(40, hi, rs);
      chk(hi == 0, "R8 no restart", hi, 0);

      // R9: internal tick mode
      mode_sync = 1'b0;
      ton_req = 8'd5;
      repeat (45) @(negedge clk);
      watch(400, hi, rs);
      chk(rs == 10, "R9 tick rate", rs, 10);
      chk(hi == 50, "R9 tick pulse total", hi, 50);
      sync_pulse(SYNC_MIN + 2);
      watch(400, hi, rs);
      chk(rs == 10, "R9 sync ignored in tick mode", rs, 10);

      finish_run();
   end

endmodule